// File: doc/BRIEF.md
# Triggered Event Merger

This block sits between several detector data sources and a downstream link framer. Each level-1 accept (L1A) strobe carries a buffer number. The block stores the strobe in a small pending queue. It then serves the pending accepts one at a time, oldest first.

For each accept, the block reads exactly one event's worth of words from each of four per-source input queues, in a fixed order: trigger data, mezzanine card 1, mezzanine card 2, tracking. It copies those words into one output queue, and each word is tagged with its source. Once the last word of the event is in the output queue, the block raises a one-cycle start request to the framer, together with the buffer number. It then waits for the framer's acknowledge before it starts the next accept.

Every input queue is first-word-fall-through and is written one word per cycle. Each word has a flag that marks the last word of that source's share of an event. The output queue is read by the framer through a plain read strobe.

Top module: `trig_event_merger`

## Requirements
- R1: After a synchronous active-high reset, `out_valid`, `fmt_start`, `acc_ovf` and every bit of `src_full` are 0.
- R2: At most four accepts are pending. An accept is pending from the edge that takes it until the start request of its event. An `l1a` sampled while four are pending is discarded: it never yields an event, even if a pending entry leaves in the same cycle. It also sets `acc_ovf`, which then stays 1 until reset.
- R3: Events are started in the order their accepts were taken. `fmt_buf` shows the `l1a_buf` value sampled with that accept while `fmt_start` is 1.
- R4: A merged event holds all trigger words (`out_src`=0), then card 1 (1), then card 2 (2), then tracking (3). Within each source the words keep their write order, and the data is unchanged.
- R5: A source contributes its words up to and including the first word whose end flag is set. Words written after that word stay queued for the next event.
- R6: `out_last` is 1 only on the tracking word whose end flag is set, i.e. the final word of each merged event.
- R7: When the output queue (8 words by default) is full, merging pauses. No word is lost, duplicated or reordered, and merging resumes as the framer reads.
- R8: `fmt_start` is 1 for exactly one cycle per event. It rises in the first cycle in which the event's final word is readable. With all n words already queued and room at the output, one word moves per cycle, and `fmt_start` is high in the cycle that follows n+1 clock edges after the edge that took the accept.
- R9: After a start request, no word of any later event enters the output queue until `fmt_ack` has been sampled high. This sampling begins in the cycle after `fmt_start`.
- R10: The trigger-data input queue holds four 64-bit words. `src_full[0]` is 1 the cycle after the fourth unread write, and a write while full is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l1a | input | 1 | Level-1 accept strobe, one cycle per accept |
| l1a_buf | input | BW (4) | Buffer number sampled with `l1a` |
| src_wr | input | NSRC (4) | Per-source write strobe; bit 0 trigger, 1 card 1, 2 card 2, 3 tracking |
| src_data | input | NSRC*DW (256) | Per-source write data, source g in bits g*DW +: DW |
| src_eoe | input | NSRC (4) | Per-source end-of-event flag for the word being written |
| src_full | output | NSRC (4) | Per-source input queue full |
| out_rd | input | 1 | Pops the head of the output queue |
| out_valid | output | 1 | Output queue not empty |
| out_data | output | DW (64) | Output head data |
| out_src | output | SW (2) | Source code of the output head word |
| out_last | output | 1 | Output head is the final word of its event |
| fmt_start | output | 1 | One-cycle start request to the framer |
| fmt_buf | output | BW (4) | Buffer number of the event being started |
| fmt_ack | input | 1 | Framer acknowledge of the start request |
| acc_ovf | output | 1 | Sticky accept-queue overflow |

## Verification
A write to any queue takes effect on the clock edge that samples it. So `src_full` and `acc_ovf` change one cycle after the causing strobe, and an output word is readable one cycle after the edge that moves it. A taken accept is picked up on the next edge, and the words then move one per cycle. That puts the start pulse for an n-word event n+1 edges after the accept edge. The bench drives every input and samples every output on the falling clock edge. It counts falling edges from the accept to time the start pulse exactly, and it polls `out_valid` one falling edge at a time wherever only order and content matter.

// File: rtl/tem_pkg.sv
package tem_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRAIN = 2'd1,
    ST_START = 2'd2,
    ST_WAIT  = 2'd3
  } mstate_t;

  // Circular pointer advance for a queue of any depth.
  function automatic int wrap_inc(input int p, input int depth);
    return (p + 1 >= depth) ? 0 : p + 1;
  endfunction

  // Source that follows the given one in the fixed drain order.
  function automatic int next_src(input int s);
    return s + 1;
  endfunction

  // True when the given source is the final one of the drain order.
  function automatic logic is_final_src(input int s, input int nsrc);
    return s == nsrc - 1;
  endfunction

endpackage

// File: rtl/tem_fwft_fifo.sv
module tem_fwft_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          wr_ok, rd_ok;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign wr_ok   = wr_en && !full;
  assign rd_ok   = rd_en && !empty;
  assign rd_data = mem[rptr];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (wr_ok) wptr <= PW'(tem_pkg::wrap_inc(int'(wptr), DEPTH));
      if (rd_ok) rptr <= PW'(tem_pkg::wrap_inc(int'(rptr), DEPTH));
      cnt <= cnt + CW'(wr_ok) - CW'(rd_ok);
    end
  end

endmodule

// File: rtl/tem_accept_queue.sv
module tem_accept_queue #(
  parameter int BW     = 4,
  parameter int QDEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          l1a,
  input  logic [BW-1:0] l1a_buf,
  input  logic          pop,
  output logic [BW-1:0] head_buf,
  output logic          empty,
  output logic          taken,
  output logic          ovf
);

  logic q_full;
  logic dropped;

  assign taken   = l1a && !q_full;
  assign dropped = l1a && q_full;

  tem_fwft_fifo #(.W(BW), .DEPTH(QDEPTH)) u_q (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (l1a),
    .wr_data (l1a_buf),
    .rd_en   (pop),
    .rd_data (head_buf),
    .empty   (empty),
    .full    (q_full)
  );

  always_ff @(posedge clk) begin
    if (rst) ovf <= 1'b0;
    else if (dropped) ovf <= 1'b1;
  end

endmodule

// File: rtl/tem_merge_ctrl.sv
module tem_merge_ctrl #(
  parameter int NSRC = 4,
  parameter int BW   = 4,
  localparam int SW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            q_empty,
  input  logic [BW-1:0]   q_head,
  input  logic [NSRC-1:0] src_empty,
  input  logic [NSRC-1:0] src_eoe,
  input  logic            o_full,
  input  logic            fmt_ack,
  output logic            q_pop,
  output logic [NSRC-1:0] src_pop,
  output logic [SW-1:0]   sel,
  output logic            o_push,
  output logic            o_last,
  output logic            fmt_start,
  output logic [BW-1:0]   fmt_buf,
  output logic            in_wait
);

  import tem_pkg::*;

  mstate_t st;
  logic    step;
  logic    at_final;

  assign at_final  = is_final_src(int'(sel), NSRC);
  assign step      = (st == ST_DRAIN) && !src_empty[sel] && !o_full;
  assign src_pop   = step ? (NSRC'(1) << sel) : '0;
  assign o_push    = step;
  assign o_last    = step && src_eoe[sel] && at_final;
  assign fmt_start = (st == ST_START);
  assign q_pop     = (st == ST_START);
  assign in_wait   = (st == ST_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      sel     <= '0;
      fmt_buf <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (!q_empty) begin
            fmt_buf <= q_head;
            sel     <= '0;
            st      <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (step && src_eoe[sel]) begin
            if (at_final) st <= ST_START;
            else          sel <= SW'(next_src(int'(sel)));
          end
        end
        ST_START: st <= ST_WAIT;
        ST_WAIT:  if (fmt_ack) st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/trig_event_merger.sv
module trig_event_merger #(
  parameter int DW        = 64,
  parameter int NSRC      = 4,
  parameter int BW        = 4,
  parameter int QDEPTH    = 4,
  parameter int TRG_DEPTH = 4,
  parameter int SRC_DEPTH = 16,
  parameter int OUT_DEPTH = 8,
  localparam int SW       = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               l1a,
  input  logic [BW-1:0]      l1a_buf,
  input  logic [NSRC-1:0]    src_wr,
  input  logic [NSRC*DW-1:0] src_data,
  input  logic [NSRC-1:0]    src_eoe,
  output logic [NSRC-1:0]    src_full,
  input  logic               out_rd,
  output logic               out_valid,
  output logic [DW-1:0]      out_data,
  output logic [SW-1:0]      out_src,
  output logic               out_last,
  output logic               fmt_start,
  output logic [BW-1:0]      fmt_buf,
  input  logic               fmt_ack,
  output logic               acc_ovf
);

  localparam int OW = DW + SW + 1;

  // Named internal events, also observed by the bound checker.
  logic [BW-1:0]   q_head;
  logic            q_empty, q_taken, q_pop;
  logic [DW:0]     src_head [NSRC];
  logic [NSRC-1:0] src_empty, head_eoe, src_pop;
  logic [SW-1:0]   sel;
  logic [DW:0]     cur_head;
  logic            o_push, o_last, o_full, o_empty, in_wait;
  logic [OW-1:0]   o_wr, o_rd;

  tem_accept_queue #(.BW(BW), .QDEPTH(QDEPTH)) u_accq (
    .clk      (clk),
    .rst      (rst),
    .l1a      (l1a),
    .l1a_buf  (l1a_buf),
    .pop      (q_pop),
    .head_buf (q_head),
    .empty    (q_empty),
    .taken    (q_taken),
    .ovf      (acc_ovf)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    localparam int D = (g == 0) ? TRG_DEPTH : SRC_DEPTH;
    tem_fwft_fifo #(.W(DW + 1), .DEPTH(D)) u_in (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (src_wr[g]),
      .wr_data ({src_eoe[g], src_data[g*DW +: DW]}),
      .rd_en   (src_pop[g]),
      .rd_data (src_head[g]),
      .empty   (src_empty[g]),
      .full    (src_full[g])
    );
    assign head_eoe[g] = src_head[g][DW];
  end

  tem_merge_ctrl #(.NSRC(NSRC), .BW(BW)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .q_empty   (q_empty),
    .q_head    (q_head),
    .src_empty (src_empty),
    .src_eoe   (head_eoe),
    .o_full    (o_full),
    .fmt_ack   (fmt_ack),
    .q_pop     (q_pop),
    .src_pop   (src_pop),
    .sel       (sel),
    .o_push    (o_push),
    .o_last    (o_last),
    .fmt_start (fmt_start),
    .fmt_buf   (fmt_buf),
    .in_wait   (in_wait)
  );

  assign cur_head = src_head[sel];
  assign o_wr     = {o_last, sel, cur_head[DW-1:0]};

  tem_fwft_fifo #(.W(OW), .DEPTH(OUT_DEPTH)) u_out (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (o_push),
    .wr_data (o_wr),
    .rd_en   (out_rd),
    .rd_data (o_rd),
    .empty   (o_empty),
    .full    (o_full)
  );

  assign out_valid = !o_empty;
  assign {out_last, out_src, out_data} = o_rd;

endmodule

// File: rtl/tem_merge_chk.sv
module tem_merge_chk #(
  parameter int NSRC   = 4,
  parameter int BW     = 4,
  parameter int QDEPTH = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            l1a,
  input logic            q_taken,
  input logic            q_pop,
  input logic            acc_ovf,
  input logic            fmt_start,
  input logic            fmt_ack,
  input logic [BW-1:0]   fmt_buf,
  input logic            in_wait,
  input logic            o_push,
  input logic            o_full,
  input logic            out_valid,
  input logic [NSRC-1:0] src_pop,
  input logic [NSRC-1:0] src_empty
);

  logic [7:0] pend;

  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= pend + 8'(q_taken) - 8'(q_pop);
  end

  // R2
  pend_bound_chk: assert property (@(posedge clk) disable iff (rst)
    pend <= 8'(QDEPTH));

  // R2
  ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
    (l1a && pend == 8'(QDEPTH)) |=> acc_ovf);

  // R2
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    acc_ovf |=> acc_ovf);

  // R2
  ovf_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (!acc_ovf && !(l1a && pend == 8'(QDEPTH))) |=> !acc_ovf);

  // R5
  one_src_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(src_pop) && ((src_pop & src_empty) == '0));

  // R7
  push_room_chk: assert property (@(posedge clk) disable iff (rst)
    o_push |-> !o_full);

  // R8
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    fmt_start |=> !fmt_start);

  // R8
  start_data_chk: assert property (@(posedge clk) disable iff (rst)
    fmt_start |-> out_valid);

  // R9
  wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
    in_wait |-> (!o_push && src_pop == '0));

  // R3
  buf_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (in_wait && !fmt_ack) |=> $stable(fmt_buf));

endmodule

bind trig_event_merger tem_merge_chk #(.NSRC(NSRC), .BW(BW), .QDEPTH(QDEPTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .l1a       (l1a),
  .q_taken   (q_taken),
  .q_pop     (q_pop),
  .acc_ovf   (acc_ovf),
  .fmt_start (fmt_start),
  .fmt_ack   (fmt_ack),
  .fmt_buf   (fmt_buf),
  .in_wait   (in_wait),
  .o_push    (o_push),
  .o_full    (o_full),
  .out_valid (out_valid),
  .src_pop   (src_pop),
  .src_empty (src_empty)
);

// File: tb/trig_event_merger_tb.sv
module trig_event_merger_tb;

  localparam int DW = 64, NSRC = 4, BW = 4, SW = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic               rst = 1'b1, l1a = 1'b0, out_rd = 1'b0, fmt_ack = 1'b0;
  logic [BW-1:0]      l1a_buf = '0;
  logic [NSRC-1:0]    src_wr = '0, src_eoe = '0, src_full;
  logic [NSRC*DW-1:0] src_data = '0;
  logic               out_valid, out_last, fmt_start, acc_ovf;
  logic [DW-1:0]      out_data;
  logic [SW-1:0]      out_src;
  logic [BW-1:0]      fmt_buf;

  int total = 0, bad = 0, n_start = 0;
  logic [BW-1:0] buf_log [0:63];
  bit auto_ack = 1'b1, ack_req = 1'b0;
  int ev_cnt [0:7][0:3];
  logic [63:0] ev_base [0:7][0:3];

  trig_event_merger u_dut (
    .clk(clk), .rst(rst), .l1a(l1a), .l1a_buf(l1a_buf),
    .src_wr(src_wr), .src_data(src_data), .src_eoe(src_eoe), .src_full(src_full),
    .out_rd(out_rd), .out_valid(out_valid), .out_data(out_data), .out_src(out_src),
    .out_last(out_last), .fmt_start(fmt_start), .fmt_buf(fmt_buf),
    .fmt_ack(fmt_ack), .acc_ovf(acc_ovf)
  );

  // Start-pulse monitor and framer acknowledge model.
  always @(negedge clk) begin
    fmt_ack = 1'b0;
    if (ack_req) begin
      fmt_ack = 1'b1;
      ack_req = 1'b0;
    end
    if (fmt_start) begin
      if (n_start < 64) buf_log[n_start] = fmt_buf;
      n_start++;
      if (auto_ack) ack_req = 1'b1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_word(input int s, input logic [63:0] d, input bit e);
    src_wr[s] = 1'b1;
    src_eoe[s] = e;
    src_data[s*DW +: DW] = d;
    @(negedge clk);
    src_wr = '0;
    src_eoe = '0;
  endtask

  task automatic push_src(input int slot, input int s, input int n);
    logic [63:0] base;
    base = {8'(s + 1), 8'(slot), 48'h0000_5a00_0000};
    ev_cnt[slot][s] = n;
    ev_base[slot][s] = base;
    for (int i = 0; i < n; i++) push_word(s, base + 64'(i), i == n - 1);
  endtask

  task automatic ev_fill(input int slot, input int n0, input int n1, input int n2, input int n3);
    push_src(slot, 0, n0);
    push_src(slot, 1, n1);
    push_src(slot, 2, n2);
    push_src(slot, 3, n3);
  endtask

  task automatic fire(input logic [BW-1:0] b);
    l1a = 1'b1;
    l1a_buf = b;
    @(negedge clk);
    l1a = 1'b0;
  endtask

  task automatic wait_starts(input int n);
    int guard = 0;
    while (n_start < n && guard < 500) begin
      @(negedge clk);
      guard++;
    end
  endtask

  // Reads one merged event and compares each word with the expected order.
  task automatic pull_event(input int slot, input string req);
    for (int s = 0; s < NSRC; s++) begin
      for (int i = 0; i < ev_cnt[slot][s]; i++) begin
        logic [63:0] exp;
        bit lst;
        int guard = 0;
        exp = ev_base[slot][s] + 64'(i);
        lst = (s == NSRC - 1) && (i == ev_cnt[slot][s] - 1);
        while (!out_valid && guard < 200) begin
          @(negedge clk);
          guard++;
        end
        check(out_valid && out_data == exp && int'(out_src) == s && out_last == lst,
              req, out_data, exp);
        out_rd = 1'b1;
        @(negedge clk);
        out_rd = 1'b0;
      end
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!out_valid, "R1 out_valid", 64'(out_valid), 0);
    check(!fmt_start, "R1 fmt_start", 64'(fmt_start), 0);
    check(!acc_ovf, "R1 acc_ovf", 64'(acc_ovf), 0);
    check(src_full == '0, "R1 src_full", 64'(src_full), 0);
  endtask

  task automatic t_basic();
    int s0, first;
    s0 = n_start;
    first = -1;
    ev_fill(0, 2, 1, 3, 1);
    l1a = 1'b1;
    l1a_buf = 4'd5;
    @(negedge clk);
    l1a = 1'b0;
    for (int k = 1; k <= 12; k++) begin
      if (fmt_start && first < 0) first = k;
      @(negedge clk);
    end
    check(first == 9, "R8 start cycle", 64'(first), 9);
    check(n_start - s0 == 1, "R8 pulse width", 64'(n_start - s0), 1);
    pull_event(0, "R4/R6 basic event");
    check(buf_log[s0] == 4'd5, "R3 buffer number", 64'(buf_log[s0]), 5);
  endtask

  task automatic t_two();
    int s0;
    s0 = n_start;
    ev_fill(1, 2, 1, 1, 2);
    ev_fill(2, 2, 2, 1, 1);
    fire(4'd9);
    fire(4'd3);
    pull_event(1, "R5 first of two");
    pull_event(2, "R5 second of two");
    wait_starts(s0 + 2);
    check(buf_log[s0] == 4'd9, "R3 order first", 64'(buf_log[s0]), 9);
    check(buf_log[s0 + 1] == 4'd3, "R3 order second", 64'(buf_log[s0 + 1]), 3);
  endtask

  task automatic t_ack_gate();
    int s0;
    s0 = n_start;
    auto_ack = 1'b0;
    ev_fill(3, 1, 1, 1, 1);
    ev_fill(4, 1, 2, 1, 1);
    fire(4'd6);
    fire(4'd7);
    wait_starts(s0 + 1);
    repeat (15) @(negedge clk);
    pull_event(3, "R9 event before ack");
    check(!out_valid, "R9 nothing after gate", 64'(out_valid), 0);
    check(n_start == s0 + 1, "R9 no second start", 64'(n_start - s0), 1);
    ack_req = 1'b1;
    pull_event(4, "R9 event after ack");
    wait_starts(s0 + 2);
    ack_req = 1'b1;
    repeat (3) @(negedge clk);
    auto_ack = 1'b1;
  endtask

  task automatic t_stall();
    int s0;
    s0 = n_start;
    ev_fill(5, 4, 6, 2, 1);
    fire(4'd2);
    repeat (30) @(negedge clk);
    check(n_start == s0, "R7 no start while full", 64'(n_start - s0), 0);
    check(out_valid, "R7 words held", 64'(out_valid), 1);
    pull_event(5, "R7 stalled event");
    wait_starts(s0 + 1);
    check(n_start == s0 + 1 && buf_log[s0] == 4'd2, "R7 start after drain", 64'(buf_log[s0]), 2);
  endtask

  task automatic t_trig_full();
    push_src(6, 0, 4);
    check(src_full[0], "R10 trigger full", 64'(src_full), 1);
    check(!src_full[1], "R10 card queue not full", 64'(src_full[1]), 0);
    push_word(0, 64'hDEAD_BEEF, 1'b1);
    push_src(6, 1, 1);
    push_src(6, 2, 1);
    push_src(6, 3, 1);
    fire(4'd4);
    pull_event(6, "R10 four words kept");
    ev_fill(7, 1, 1, 1, 1);
    fire(4'd11);
    pull_event(7, "R10 dropped word absent");
    repeat (4) @(negedge clk);
    check(!out_valid && src_full == '0, "R10 queues empty", 64'(src_full), 0);
  endtask

  task automatic t_overflow();
    int s0;
    s0 = n_start;
    for (int i = 1; i <= 4; i++) fire(BW'(i));
    check(!acc_ovf, "R2 four pending", 64'(acc_ovf), 0);
    fire(4'd8);
    check(acc_ovf, "R2 fifth sets overflow", 64'(acc_ovf), 1);
    for (int e = 0; e < 4; e++) ev_fill(e, 1, 1, 1, 1);
    for (int e = 0; e < 4; e++) pull_event(e, "R2 queued event");
    repeat (20) @(negedge clk);
    check(n_start == s0 + 4, "R2 fifth discarded", 64'(n_start - s0), 4);
    for (int e = 0; e < 4; e++)
      check(buf_log[s0 + e] == BW'(e + 1), "R2 kept buffers", 64'(buf_log[s0 + e]), 64'(e + 1));
    check(acc_ovf, "R2 overflow sticky", 64'(acc_ovf), 1);
    check(!out_valid, "R2 no extra words", 64'(out_valid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not complete");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_basic();
    t_two();
    t_ack_gate();
    t_stall();
    t_trig_full();
    t_overflow();
    t_reset();
    check(!acc_ovf, "R2 cleared by reset", 64'(acc_ovf), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule